// File: doc/BRIEF.md
# Interlaced 525-Line Monochrome Raster Timing Generator

This block produces the complete line and field timing for a black-and-white interlaced raster of 525 lines per frame. It is split into two fields of 262.5 lines each, at 60 fields per second. A single clock at four times the colour-burst rate drives it, which gives 910 clocks per line. Each line begins with its blanking interval: a front porch of about 0.02 of the line, then the sync tip (0.08), then the back porch (0.06), then the visible part. The two fields are offset by half a line. The first field ends halfway through frame line 262, and the second field begins its vertical sync interval at that midpoint.

The outputs are the pixel position within the line, the frame line number, an odd/even field flag, the horizontal and vertical blanking flags, a composite sync (active low), and an active-picture flag. A 2-bit level code tells a downstream DAC which analog target to use: the sync tip below blank, blank, black, or white. An 8-bit luminance input passes to `luma_o` only while the active-picture flag is high. The DAC scales from black toward white by that byte. Vertical sync is simplified to broad pulses on six consecutive half-lines with no equalizing pulses.

Top module: `rs170_raster_gen`

## Requirements
- R1: `hpos_o` counts 0 to LINE_CLKS-1 (default 909) and wraps to 0. `line_o` advances by one only on the wrap and counts 0 to FRAME_LINES-1 (default 524) before returning to 0.
- R2: `hblank_o` is high exactly while `hpos_o` < HFP+HSW+HBP (default 146). Within that span the order is front porch (hpos 0..17), sync tip (18..90) and back porch (91..145). Visible clocks are 146..909.
- R3: `field_odd_o` is 1 from line 0 hpos 0 up to line 262 hpos 454. It is 0 from line 262 hpos 455 to the end of line 524. Line 262 is F2 = (FRAME_LINES-1)/2, and 455 is half the line.
- R4: `vblank_o` is high on lines 0..VBLANK_LINES-1 (default 0..19) and on lines F2..F2+VBLANK_LINES (default 262..282). This leaves 242 visible lines per field and 484 per frame.
- R5: Each field opens with 2*VSYNC_LINES half-lines (default 6) of broad pulses. These half-lines start at line 0 hpos 0 for the odd field and at line 262 hpos 455 for the even field. On each of them, `csync_n_o` is low for the first HALF-BROAD_HIGH clocks (default 388) of the half-line and high for the remaining BROAD_HIGH (67). No normal line pulse occurs there.
- R6: Outside the broad-pulse half-lines, `csync_n_o` is low exactly on hpos HFP..HFP+HSW-1 (default 18..90).
- R7: `active_o` is high exactly when neither blanking flag is high. `luma_o` equals `luma_i` while `active_o` is high and is 0 otherwise.
- R8: The encoding of `level_o` is 2'b00 sync tip, 2'b01 blank, 2'b10 black, 2'b11 white. The code is 2'b00 exactly when `csync_n_o` is low. Otherwise it is 2'b01 while `active_o` is low. While `active_o` is high it is 2'b11 if `luma_i` is 255 and 2'b10 for any other value, with `luma_o` = 0 meaning pure black.
- R9: A clock edge with `rst_n` low puts the generator at line 0, hpos 0, odd field, with both blanking flags high. Counting restarts from there on the first edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock (910 per line by default) |
| rst_n | input | 1 | Synchronous reset, active low |
| luma_i | input | 8 | Luminance of the current pixel, 0 black to 255 white |
| hpos_o | output | 10 | Clock position within the current line |
| line_o | output | 10 | Line number within the 525-line frame |
| field_odd_o | output | 1 | 1 during the odd field, 0 during the even field |
| hblank_o | output | 1 | Horizontal blanking interval |
| vblank_o | output | 1 | Vertical blanking interval |
| csync_n_o | output | 1 | Composite sync, low at the sync tip |
| active_o | output | 1 | Visible picture region |
| level_o | output | 2 | Analog target code: 00 sync, 01 blank, 10 black, 11 white |
| luma_o | output | 8 | Luminance gated to the visible region |

## Verification
Some properties hold on every cycle, and the bound assertions check those. They cover the counter stepping and wrap, the line number staying still inside a line, and the even field starting only at the mid-line point. They also check that sync never falls outside blanking, that the sync code tracks the sync pin, that the luminance stays gated, and that reset returns to the origin. The exact porch boundaries, broad-pulse widths, vertical blanking lines and the level chosen for the extreme luminance values need whole frames against an independent model. The bench provides this with random luminance mixed with forced 0 and 255 values, together with a reset in the middle of a frame.

// File: rtl/rs170_pkg.sv
// Shared types for the interlaced raster generator.
// Assumes a 2-bit level bus read by a downstream DAC.
package rs170_pkg;
    // Analog target selected for the current clock
    typedef enum logic [1:0] {
        LVL_SYNC  = 2'b00,
        LVL_BLANK = 2'b01,
        LVL_BLACK = 2'b10,
        LVL_WHITE = 2'b11
    } level_e;
endpackage

// File: rtl/rs170_hcount.sv
// Horizontal position counter.
// Counts clocks within one line and reports the position inside the
// current half-line. Assumes LINE_CLKS is even.
module rs170_hcount #(
    parameter int LINE_CLKS = 910,
    parameter int HW        = $clog2(LINE_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hpos,
    output logic          eol,
    output logic          second_half,
    output logic [HW-1:0] half_pos
);
    localparam logic [HW-1:0] LAST_H = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] HALF_H = HW'(LINE_CLKS / 2);

    // Advance the clock position and wrap at the end of the line
    always_ff @(posedge clk) begin
        if (!rst_n)
            hpos <= '0;
        else if (hpos == LAST_H)
            hpos <= '0;
        else
            hpos <= hpos + 1'b1;
    end

    // End-of-line strobe and half-line position
    always_comb begin
        eol         = (hpos == LAST_H);
        second_half = (hpos >= HALF_H);
        half_pos    = second_half ? (hpos - HALF_H) : hpos;
    end
endmodule

// File: rtl/rs170_vcount.sv
// Frame line counter and field flag.
// The odd field ends at the midpoint of line F2 and the even field
// ends at the end of the last frame line. Assumes FRAME_LINES is odd.
module rs170_vcount #(
    parameter int LINE_CLKS   = 910,
    parameter int FRAME_LINES = 525,
    parameter int HW          = $clog2(LINE_CLKS),
    parameter int VW          = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eol,
    input  logic [HW-1:0] hpos,
    output logic [VW-1:0] line,
    output logic          field_odd
);
    localparam logic [VW-1:0] LAST_L     = VW'(FRAME_LINES - 1);
    localparam logic [VW-1:0] F2_L       = VW'((FRAME_LINES - 1) / 2);
    localparam logic [HW-1:0] HALF_PRE_H = HW'(LINE_CLKS / 2 - 1);

    // Step the frame line at each end of line
    always_ff @(posedge clk) begin
        if (!rst_n)
            line <= '0;
        else if (eol)
            line <= (line == LAST_L) ? '0 : line + 1'b1;
    end

    // Switch field at the mid-line point and at the frame wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_odd <= 1'b1;
        else if (line == F2_L && hpos == HALF_PRE_H)
            field_odd <= 1'b0;
        else if (eol && line == LAST_L)
            field_odd <= 1'b1;
    end
endmodule

// File: rtl/rs170_sync_decode.sv
// Blanking and composite sync decode.
// Works from the counters only. Broad pulses cover 2*VSYNC_LINES
// half-lines from the start of each field. The half-line index is
// {line, second_half}, i.e. 2*line + second_half.
module rs170_sync_decode #(
    parameter int LINE_CLKS    = 910,
    parameter int FRAME_LINES  = 525,
    parameter int HFP          = 18,
    parameter int HSW          = 73,
    parameter int HBP          = 55,
    parameter int VSYNC_LINES  = 3,
    parameter int VBLANK_LINES = 20,
    parameter int BROAD_HIGH   = 67,
    parameter int HW           = $clog2(LINE_CLKS),
    parameter int VW           = $clog2(FRAME_LINES)
) (
    input  logic [HW-1:0] hpos,
    input  logic          second_half,
    input  logic [HW-1:0] half_pos,
    input  logic [VW-1:0] line,
    output logic          hblank,
    output logic          vblank,
    output logic          csync_n
);
    localparam int F2 = (FRAME_LINES - 1) / 2;
    localparam logic [HW-1:0] ACT_H      = HW'(HFP + HSW + HBP);
    localparam logic [HW-1:0] HS_BEG_H   = HW'(HFP);
    localparam logic [HW-1:0] HS_END_H   = HW'(HFP + HSW);
    localparam logic [HW-1:0] BROAD_LO_H = HW'(LINE_CLKS / 2 - BROAD_HIGH);
    localparam logic [VW-1:0] VBL_L      = VW'(VBLANK_LINES);
    localparam logic [VW-1:0] F2_L       = VW'(F2);
    localparam logic [VW-1:0] EVEN_ACT_L = VW'(F2 + 1 + VBLANK_LINES);
    localparam logic [VW:0]   VS_HL      = (VW+1)'(2 * VSYNC_LINES);
    localparam logic [VW:0]   EVEN_HL    = (VW+1)'(FRAME_LINES);
    localparam logic [VW:0]   EVEN_HL_E  = (VW+1)'(FRAME_LINES + 2 * VSYNC_LINES);

    logic [VW:0] half_idx;
    logic        in_vsync;
    logic        broad_low;
    logic        line_pulse;

    // Locate the broad-pulse half-lines of both fields
    always_comb begin
        half_idx = {line, second_half};
        in_vsync = (half_idx < VS_HL) ||
                   (half_idx >= EVEN_HL && half_idx < EVEN_HL_E);
    end

    // Form composite sync from broad pulses or the normal line pulse
    always_comb begin
        broad_low  = in_vsync && (half_pos < BROAD_LO_H);
        line_pulse = !in_vsync && (hpos >= HS_BEG_H) && (hpos < HS_END_H);
        csync_n    = !(broad_low || line_pulse);
    end

    // Horizontal and vertical blanking intervals
    always_comb begin
        hblank = (hpos < ACT_H);
        vblank = (line < VBL_L) || (line >= F2_L && line < EVEN_ACT_L);
    end
endmodule

// File: rtl/rs170_level_map.sv
// Output level selection.
// Picks the analog target code and gates the luminance byte to the
// visible region. Assumes full scale luminance means white.
module rs170_level_map
    import rs170_pkg::*;
#(
    parameter int LUMA_W = 8
) (
    input  logic              hblank,
    input  logic              vblank,
    input  logic              csync_n,
    input  logic [LUMA_W-1:0] luma_i,
    output logic              active,
    output level_e            level,
    output logic [LUMA_W-1:0] luma_o
);
    localparam logic [LUMA_W-1:0] FULL = '1;

    // Visible region and gated luminance
    always_comb begin
        active = !hblank && !vblank;
        luma_o = active ? luma_i : '0;
    end

    // Sync has priority, then blank, then picture level
    always_comb begin
        if (!csync_n)
            level = LVL_SYNC;
        else if (!active)
            level = LVL_BLANK;
        else if (luma_i == FULL)
            level = LVL_WHITE;
        else
            level = LVL_BLACK;
    end
endmodule

// File: rtl/rs170_raster_gen.sv
// Interlaced 525-line monochrome raster timing generator (top).
// One pixel-rate clock and synchronous active-low reset. All outputs
// decode from the counter state in the same cycle; luma is a
// combinational pass-through gated by the visible region.
module rs170_raster_gen
    import rs170_pkg::*;
#(
    parameter int LINE_CLKS    = 910,
    parameter int FRAME_LINES  = 525,
    parameter int HFP          = 18,
    parameter int HSW          = 73,
    parameter int HBP          = 55,
    parameter int VSYNC_LINES  = 3,
    parameter int VBLANK_LINES = 20,
    parameter int BROAD_HIGH   = 67,
    parameter int LUMA_W       = 8,
    parameter int HW           = $clog2(LINE_CLKS),
    parameter int VW           = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LUMA_W-1:0] luma_i,
    output logic [HW-1:0]     hpos_o,
    output logic [VW-1:0]     line_o,
    output logic              field_odd_o,
    output logic              hblank_o,
    output logic              vblank_o,
    output logic              csync_n_o,
    output logic              active_o,
    output logic [1:0]        level_o,
    output logic [LUMA_W-1:0] luma_o
);
    logic          eol;
    logic          second_half;
    logic [HW-1:0] half_pos;
    level_e        level;

    rs170_hcount #(.LINE_CLKS(LINE_CLKS), .HW(HW)) i_hcount (
        .clk(clk), .rst_n(rst_n), .hpos(hpos_o), .eol(eol),
        .second_half(second_half), .half_pos(half_pos)
    );

    rs170_vcount #(.LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES),
                   .HW(HW), .VW(VW)) i_vcount (
        .clk(clk), .rst_n(rst_n), .eol(eol), .hpos(hpos_o),
        .line(line_o), .field_odd(field_odd_o)
    );

    rs170_sync_decode #(.LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES),
                        .HFP(HFP), .HSW(HSW), .HBP(HBP),
                        .VSYNC_LINES(VSYNC_LINES), .VBLANK_LINES(VBLANK_LINES),
                        .BROAD_HIGH(BROAD_HIGH), .HW(HW), .VW(VW)) i_decode (
        .hpos(hpos_o), .second_half(second_half), .half_pos(half_pos),
        .line(line_o), .hblank(hblank_o), .vblank(vblank_o),
        .csync_n(csync_n_o)
    );

    rs170_level_map #(.LUMA_W(LUMA_W)) i_level (
        .hblank(hblank_o), .vblank(vblank_o), .csync_n(csync_n_o),
        .luma_i(luma_i), .active(active_o), .level(level), .luma_o(luma_o)
    );

    // Present the level code as a plain vector
    assign level_o = level;
endmodule

// File: rtl/rs170_raster_chk.sv
// Property checker for the raster generator, bound to the top module.
// Assumes the same parameter values as the instance it is bound to.
module rs170_raster_chk #(
    parameter int LINE_CLKS   = 910,
    parameter int FRAME_LINES = 525,
    parameter int LUMA_W      = 8,
    parameter int HW          = $clog2(LINE_CLKS),
    parameter int VW          = $clog2(FRAME_LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HW-1:0]     hpos_o,
    input logic [VW-1:0]     line_o,
    input logic              field_odd_o,
    input logic              hblank_o,
    input logic              vblank_o,
    input logic              csync_n_o,
    input logic              active_o,
    input logic [1:0]        level_o,
    input logic [LUMA_W-1:0] luma_o
);
    localparam logic [HW-1:0] LAST_H = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] HALF_H = HW'(LINE_CLKS / 2);
    localparam logic [VW-1:0] F2_L   = VW'((FRAME_LINES - 1) / 2);

    assert_hpos_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos_o == LAST_H) |=> (hpos_o == '0));

    assert_hpos_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos_o != LAST_H) |=> (hpos_o == $past(hpos_o) + 1'b1));

    assert_line_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos_o != LAST_H) |=> $stable(line_o));

    assert_sync_in_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !csync_n_o |-> (hblank_o || vblank_o));

    assert_even_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(field_odd_o) |-> (line_o == F2_L && hpos_o == HALF_H));

    assert_luma_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (luma_o == '0));

    assert_sync_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csync_n_o == (level_o != 2'b00)));

    assert_reset_origin_R9: assert property (@(posedge clk)
        !rst_n |=> (hpos_o == '0 && line_o == '0 && field_odd_o && hblank_o && vblank_o));
endmodule

bind rs170_raster_gen rs170_raster_chk #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .LUMA_W(LUMA_W),
    .HW(HW), .VW(VW)
) i_rs170_raster_chk (
    .clk(clk), .rst_n(rst_n), .hpos_o(hpos_o), .line_o(line_o),
    .field_odd_o(field_odd_o), .hblank_o(hblank_o), .vblank_o(vblank_o),
    .csync_n_o(csync_n_o), .active_o(active_o), .level_o(level_o),
    .luma_o(luma_o)
);

// File: tb/test_rs170_raster_gen.sv
// Bench for the raster generator: reduced raster geometry, random
// luminance with forced extremes, whole-frame comparison to a model.
module test_rs170_raster_gen;
    localparam int LC  = 60;
    localparam int FL  = 31;
    localparam int HFP = 2;
    localparam int HSW = 5;
    localparam int HBP = 4;
    localparam int VSL = 2;
    localparam int VBL = 4;
    localparam int BH  = 6;
    localparam int HW  = $clog2(LC);
    localparam int VW  = $clog2(FL);
    localparam int HALF = LC / 2;
    localparam int F2   = (FL - 1) / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    luma_i = 8'd0;
    logic [HW-1:0] hpos_o;
    logic [VW-1:0] line_o;
    logic          field_odd_o, hblank_o, vblank_o, csync_n_o, active_o;
    logic [1:0]    level_o;
    logic [7:0]    luma_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rs170_raster_gen #(
        .LINE_CLKS(LC), .FRAME_LINES(FL), .HFP(HFP), .HSW(HSW), .HBP(HBP),
        .VSYNC_LINES(VSL), .VBLANK_LINES(VBL), .BROAD_HIGH(BH)
    ) i_rs170_raster_gen (
        .clk(clk), .rst_n(rst_n), .luma_i(luma_i), .hpos_o(hpos_o),
        .line_o(line_o), .field_odd_o(field_odd_o), .hblank_o(hblank_o),
        .vblank_o(vblank_o), .csync_n_o(csync_n_o), .active_o(active_o),
        .level_o(level_o), .luma_o(luma_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d (hpos=%0d line=%0d)",
                     req, act, exp, hpos_o, line_o);
        end
    endtask

    // Model functions written from the requirements
    function automatic bit m_field(input int h, input int l);
        return (l < F2) || (l == F2 && h < HALF);
    endfunction
    function automatic bit m_hblank(input int h);
        return h < HFP + HSW + HBP;
    endfunction
    function automatic bit m_vblank(input int l);
        return (l < VBL) || (l >= F2 && l <= F2 + VBL);
    endfunction
    function automatic bit m_broad(input int h, input int l);
        int hl = 2 * l + h / HALF;
        return (hl < 2 * VSL) || (hl >= FL && hl < FL + 2 * VSL);
    endfunction
    function automatic bit m_sync_n(input int h, input int l);
        if (m_broad(h, l))
            return (h % HALF) >= HALF - BH;
        return !(h >= HFP && h < HFP + HSW);
    endfunction
    function automatic int m_level(input int h, input int l, input int y);
        if (!m_sync_n(h, l)) return 0;
        if (m_hblank(h) || m_vblank(l)) return 1;
        return (y == 255) ? 3 : 2;
    endfunction

    // Compare every output against the model at the current point
    task automatic compare_all(input int h, input int l);
        bit act = !m_hblank(h) && !m_vblank(l);
        check(hpos_o == h, "R1 hpos", hpos_o, h);
        check(line_o == l, "R1 line", line_o, l);
        check(hblank_o == m_hblank(h), "R2 hblank", hblank_o, m_hblank(h));
        check(field_odd_o == m_field(h, l), "R3 field", field_odd_o, m_field(h, l));
        check(vblank_o == m_vblank(l), "R4 vblank", vblank_o, m_vblank(l));
        if (m_broad(h, l))
            check(csync_n_o == m_sync_n(h, l), "R5 broad pulse", csync_n_o, m_sync_n(h, l));
        else
            check(csync_n_o == m_sync_n(h, l), "R6 line pulse", csync_n_o, m_sync_n(h, l));
        check(active_o == act, "R7 active", active_o, act);
        check(luma_o == (act ? luma_i : 8'd0), "R7 luma gate", luma_o, act ? luma_i : 0);
        check(level_o == m_level(h, l, luma_i), "R8 level", level_o, m_level(h, l, luma_i));
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int h = 0;
        int l = 0;
        int r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        check(hpos_o == 0 && line_o == 0, "R9 reset origin", hpos_o + line_o, 0);
        check(field_odd_o == 1'b1, "R9 reset odd field", field_odd_o, 1);
        check(hblank_o && vblank_o, "R9 reset blanking", hblank_o + vblank_o, 2);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 3 * LC * FL + 200; cyc++) begin
            // Mid-frame reset, R9
            if (cyc == LC * FL + 7 * LC + 33) begin
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
                h = 0;
                l = 0;
                check(hpos_o == 0 && line_o == 0 && field_odd_o,
                      "R9 mid-frame reset", hpos_o + line_o, 0);
            end
            compare_all(h, l);
            r = $urandom % 8;
            if (r == 0)      luma_i = 8'd0;
            else if (r == 1) luma_i = 8'd255;
            else             luma_i = 8'($urandom);
            if (h == LC - 1) begin
                h = 0;
                l = (l == FL - 1) ? 0 : l + 1;
            end else begin
                h = h + 1;
            end
            @(negedge clk);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule